// File: doc/BRIEF.md
# Dead-Time PWM Timer

An 8-bit timer that advances by one on each cycle where its count-enable input is high. The enable stands in for a divided timer clock. A top register sets where the count turns back to zero, and two compare channels watch the count. Each channel drives a pin pair made of a true output and a complementary output.

A channel in PWM mode makes a waveform whose period is set by the top register. Its two pins are never high together, and a one-tick gap where both are low separates every change of phase. A channel outside PWM mode has a single output. A compare hit can toggle, clear or set that output, and so can a software force strobe. The timer can be told to clear the count when it hits the top value.

Software uses one write port for every register: control, counter, top, the two compares, the force strobes and the write-one-to-clear flags. The count and the flags are visible as outputs.

Top module: `pwm_dead_timer`

## Requirements
- R1: After reset the count is 0, all flags are 0, all pin outputs are low, top is 255 and the compares are 0.
- R2: The count goes up by one on each cycle with `countEn` high and no counter write. In all other cycles it keeps its value. Counter address 1 loads `wrData` directly, and a load takes priority over counting.
- R3: When control bit 2 (clear-on-top) is set, or any channel is in PWM mode, a tick taken at count == top loads 0 and sets the overflow flag (flag bit 2). The period is therefore top+1 ticks.
- R4: A channel's match flag (flag bit i) is set when a tick brings the count to that channel's compare value. Writing the counter to a compare or top value sets no flag.
- R5: Writing 1 to a flag bit at address 6 clears it. Writing 0 leaves it unchanged.
- R6: A channel outside PWM mode uses the mode field in control bits [4:3] for channel 0 and [6:5] for channel 1. On a match, 01 toggles the output, 10 clears it and 11 sets it. With 00 the pin is low. Outside PWM mode the complementary pin is always low.
- R7: Writing 1 to bit i at address 5 applies channel i's mode action immediately. It sets no flag, it is never stored, and it has no effect in PWM mode.
- R8: In PWM mode a channel's true and complementary pins are never high in the same cycle.
- R9: Control bit i puts channel i in PWM mode. With 0 < compare C < top T and mode 01 or 10, the true pin is high only at count values 1 to C-1. The complementary pin is high only at count values C+1 to T. The counts 0 and C are both-low gaps.
- R10: In PWM mode a compare of 0 holds the true pin low and the complementary pin high. A compare equal to top holds the true pin high and the complementary pin low. Mode 11 inverts the polarity, which swaps these levels.
- R11: In PWM mode, mode 00 holds both pins of the pair low.
- R12: Without clear-on-top and without PWM, the count wraps from 255 to 0 and sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| countEn | input | 1 | Timer tick enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Addresses: 0 control, 1 counter, 2 top, 3/4 compare 0/1, 5 force, 6 flags |
| wrData | input | 8 | Write data |
| count | output | 8 | Current count |
| outTrue | output | 2 | True pin for each channel |
| outComp | output | 2 | Complementary pin for each channel |
| matchFlag | output | 2 | Compare match flags |
| ovfFlag | output | 1 | Overflow flag |

## Verification
The checker assumes that a counter write and a tick never count together within one cycle, since the load always wins. It also assumes that the flag-clear property holds only in cycles where no tick could set the overflow flag again. The stimulus changes inputs on the falling edge, drives ticks as single-cycle pulses between writes, and never raises a tick in the same cycle as a write. Mode changes are made only while the waveform being checked is not in a measured window. The both-high property on each pair is left unconditional and so covers every mode switch as well.

// File: rtl/pwm_dead_timer_pkg.sv
package pwm_dead_timer_pkg;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;
  localparam int CTRL_BITS = 3 * NUM_CH + 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOP   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FORCE = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd6;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  typedef struct packed {
    logic              load;
    logic [NUM_CH-1:0] forceHit;
  } strobe_t;
endpackage

// File: rtl/pdt_ctrl.sv
module pdt_ctrl
  import pwm_dead_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [W-1:0]             wrData,
  input  logic [NUM_CH-1:0]        matchEv,
  input  logic                     ovfEv,
  output strobe_t                  stb,
  output logic [NUM_CH-1:0]        pwmOn,
  output logic                     ctcOn,
  output logic [NUM_CH-1:0][1:0]   modeSel,
  output logic [W-1:0]             topVal,
  output logic [NUM_CH-1:0][W-1:0] cmpVal,
  output logic [NUM_CH-1:0]        matchFlag,
  output logic                     ovfFlag
);
  logic [CTRL_BITS-1:0] ctrlReg;
  logic wrFlags;

  assign wrFlags = wrEn && (wrAddr == A_FLAGS);

  always_comb begin
    stb.load     = wrEn && (wrAddr == A_COUNT);
    stb.forceHit = (wrEn && (wrAddr == A_FORCE)) ? wrData[NUM_CH-1:0] : '0;
  end

  assign pwmOn = ctrlReg[NUM_CH-1:0];
  assign ctcOn = ctrlReg[NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      topVal  <= '1;
      ovfFlag <= 1'b0;
    end else begin
      if (wrEn && (wrAddr == A_CTRL)) ctrlReg <= wrData[CTRL_BITS-1:0];
      if (wrEn && (wrAddr == A_TOP))  topVal  <= wrData;
      ovfFlag <= (ovfFlag & ~(wrFlags & wrData[NUM_CH])) | ovfEv;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign modeSel[i] = ctrlReg[NUM_CH+1+2*i +: 2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpVal[i]    <= '0;
        matchFlag[i] <= 1'b0;
      end else begin
        if (wrEn && (wrAddr == A_CMP0 + ADDR_W'(i))) cmpVal[i] <= wrData;
        matchFlag[i] <= (matchFlag[i] & ~(wrFlags & wrData[i])) | matchEv[i];
      end
    end
  end
endmodule

// File: rtl/pdt_datapath.sv
module pdt_datapath
  import pwm_dead_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     countEn,
  input  strobe_t                  stb,
  input  logic [W-1:0]             loadVal,
  input  logic [NUM_CH-1:0]        pwmOn,
  input  logic                     ctcOn,
  input  logic [NUM_CH-1:0][1:0]   modeSel,
  input  logic [W-1:0]             topVal,
  input  logic [NUM_CH-1:0][W-1:0] cmpVal,
  output logic [W-1:0]             count,
  output logic [NUM_CH-1:0]        matchEv,
  output logic                     ovfEv,
  output logic [NUM_CH-1:0]        outTrue,
  output logic [NUM_CH-1:0]        outComp
);
  logic           wrapHit;
  logic           tickEff;
  logic [W-1:0]   nextCnt;

  always_comb begin
    wrapHit = ((|pwmOn) || ctcOn) && (count == topVal);
    nextCnt = wrapHit ? '0 : count + 1'b1;
    tickEff = countEn && !stb.load;
    ovfEv   = tickEff && (wrapHit || (count == '1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          count <= '0;
    else if (stb.load)  count <= loadVal;
    else if (countEn)   count <= nextCnt;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic rawBase, rawNow, lastRaw, ocState;
    act_e act;

    assign act        = act_e'(modeSel[i]);
    assign matchEv[i] = tickEff && (nextCnt == cmpVal[i]);

    always_comb begin
      if (cmpVal[i] == topVal)   rawBase = 1'b1;
      else if (cmpVal[i] == '0)  rawBase = 1'b0;
      else                       rawBase = (count < cmpVal[i]);
      rawNow = (act == ACT_SET) ? ~rawBase : rawBase;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lastRaw <= 1'b0;
        ocState <= 1'b0;
        outTrue[i] <= 1'b0;
        outComp[i] <= 1'b0;
      end else begin
        if (stb.load || countEn) lastRaw <= rawNow;
        if (!pwmOn[i] && (matchEv[i] || stb.forceHit[i])) begin
          case (act)
            ACT_TOGGLE: ocState <= ~ocState;
            ACT_CLEAR:  ocState <= 1'b0;
            ACT_SET:    ocState <= 1'b1;
            default:    ocState <= ocState;
          endcase
        end
        if (pwmOn[i]) begin
          if (act == ACT_NONE) begin
            outTrue[i] <= 1'b0;
            outComp[i] <= 1'b0;
          end else begin
            outTrue[i] <= rawNow & lastRaw;
            outComp[i] <= ~rawNow & ~lastRaw;
          end
        end else begin
          outTrue[i] <= (act != ACT_NONE) & ocState;
          outComp[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_dead_timer.sv
module pwm_dead_timer
  import pwm_dead_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [W-1:0]      wrData,
  output logic [W-1:0]      count,
  output logic [NUM_CH-1:0] outTrue,
  output logic [NUM_CH-1:0] outComp,
  output logic [NUM_CH-1:0] matchFlag,
  output logic              ovfFlag
);
  strobe_t                  stb;
  logic [NUM_CH-1:0]        pwmOn;
  logic                     ctcOn;
  logic [NUM_CH-1:0][1:0]   modeSel;
  logic [W-1:0]             topVal;
  logic [NUM_CH-1:0][W-1:0] cmpVal;
  logic [NUM_CH-1:0]        matchEv;
  logic                     ovfEv;

  pdt_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .matchEv(matchEv), .ovfEv(ovfEv), .stb(stb), .pwmOn(pwmOn), .ctcOn(ctcOn),
    .modeSel(modeSel), .topVal(topVal), .cmpVal(cmpVal),
    .matchFlag(matchFlag), .ovfFlag(ovfFlag)
  );

  pdt_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .countEn(countEn), .stb(stb), .loadVal(wrData),
    .pwmOn(pwmOn), .ctcOn(ctcOn), .modeSel(modeSel), .topVal(topVal),
    .cmpVal(cmpVal), .count(count), .matchEv(matchEv), .ovfEv(ovfEv),
    .outTrue(outTrue), .outComp(outComp)
  );
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker
  import pwm_dead_timer_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              countEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [W-1:0]      wrData,
  input logic [W-1:0]      count,
  input logic [NUM_CH-1:0] outTrue,
  input logic [NUM_CH-1:0] outComp,
  input logic [NUM_CH-1:0] matchFlag,
  input logic              ovfFlag,
  input logic [NUM_CH-1:0] pwmOn,
  input logic              ctcOn,
  input logic [W-1:0]      topVal
);
  logic cntWr;
  assign cntWr = wrEn && (wrAddr == A_COUNT);

  // R2
  hold_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !cntWr) |=> $stable(count));

  // R3
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !cntWr && ((|pwmOn) || ctcOn) && (count == topVal)) |=> (count == '0) && ovfFlag);

  // R4
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> ($stable(matchFlag) && $stable(ovfFlag)));

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == A_FLAGS) && wrData[NUM_CH] && !countEn) |=> !ovfFlag);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R8
    pair_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(outTrue[i] && outComp[i]));

    // R6
    comp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !pwmOn[i] |=> !outComp[i]);
  end
endmodule

bind pwm_dead_timer pdt_checker #(.W(W)) u_pdt_checker (
  .clk(clk), .rstN(rstN), .countEn(countEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .count(count), .outTrue(outTrue), .outComp(outComp),
  .matchFlag(matchFlag), .ovfFlag(ovfFlag), .pwmOn(pwmOn), .ctcOn(ctcOn),
  .topVal(topVal)
);

// File: tb/pwm_dead_timer_bench.sv
`timescale 1ns/1ps
module pwm_dead_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       countEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] count;
  logic [1:0] outTrue, outComp, matchFlag;
  logic       ovfFlag;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_dead_timer u_pwm_dead_timer (
    .clk(clk), .rstN(rstN), .countEn(countEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .count(count), .outTrue(outTrue), .outComp(outComp),
    .matchFlag(matchFlag), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
    countEn = 1'b1;
    @(negedge clk);
    countEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 count", count, 0);
    chk("R1 flags", {ovfFlag, matchFlag}, 0);
    chk("R1 pins", {outTrue, outComp}, 0);
  endtask

  task automatic testCountHold();
    for (int k = 0; k < 3; k++) tick();
    chk("R2 count after 3 ticks", count, 3);
    repeat (5) @(negedge clk);
    chk("R2 count holds without enable", count, 3);
    wr(3'd1, 8'd40);
    chk("R2 counter load", count, 40);
  endtask

  task automatic testMatchActions();
    wr(3'd6, 8'h07);
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd2);
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h0C);
    tick();
    chk("R6 toggle before match", outTrue[0], 0);
    tick();
    chk("R4 match flag on count to compare", matchFlag[0], 1);
    chk("R6 toggle on match", outTrue[0], 1);
    tick();
    chk("R3 count reaches top", count, 3);
    tick();
    chk("R3 wrap to zero", count, 0);
    chk("R3 overflow flag", ovfFlag, 1);
    chk("R6 no action away from compare", outTrue[0], 1);
    wr(3'd0, 8'h14);
    tick(); tick();
    chk("R6 clear on match", outTrue[0], 0);
    wr(3'd0, 8'h1C);
    for (int k = 0; k < 4; k++) tick();
    chk("R6 set on match", outTrue[0], 1);
    chk("R6 comp pin low outside PWM", outComp, 0);
    wr(3'd0, 8'h04);
    chk("R6 disconnected pin low", outTrue[0], 0);
  endtask

  task automatic testSoftWrite();
    wr(3'd6, 8'h07);
    wr(3'd1, 8'd2);
    chk("R4 write equal to compare sets no flag", matchFlag, 0);
    wr(3'd1, 8'd3);
    chk("R4 write equal to top sets no flag", {ovfFlag, matchFlag}, 0);
    tick();
    chk("R3 counted wrap sets flag", ovfFlag, 1);
  endtask

  task automatic testFlagClear();
    wr(3'd6, 8'h00);
    chk("R5 writing zero keeps flag", ovfFlag, 1);
    wr(3'd6, 8'h04);
    chk("R5 write one clears flag", ovfFlag, 0);
  endtask

  task automatic testNaturalWrap();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFE);
    wr(3'd6, 8'h07);
    tick();
    chk("R12 count at max", count, 8'hFF);
    chk("R12 no flag before wrap", ovfFlag, 0);
    tick();
    chk("R12 wrap to zero", count, 0);
    chk("R12 overflow flag", ovfFlag, 1);
  endtask

  task automatic testForce();
    wr(3'd6, 8'h07);
    wr(3'd0, 8'h10);
    wr(3'd5, 8'h01);
    chk("R7 force clear", outTrue[0], 0);
    wr(3'd0, 8'h08);
    wr(3'd5, 8'h01);
    chk("R7 force toggle up", outTrue[0], 1);
    wr(3'd5, 8'h01);
    chk("R7 force toggle down", outTrue[0], 0);
    wr(3'd0, 8'h18);
    wr(3'd5, 8'h01);
    chk("R7 force set", outTrue[0], 1);
    chk("R7 force sets no flag", matchFlag, 0);
    wr(3'd0, 8'h60);
    wr(3'd5, 8'h02);
    chk("R7 force channel 1", outTrue, 2'b10);
  endtask

  task automatic testPwmWave();
    int hiCnt = 0;
    int loCnt = 0;
    wr(3'd2, 8'd5);
    wr(3'd3, 8'd2);
    wr(3'd1, 8'd0);
    wr(3'd6, 8'h07);
    wr(3'd0, 8'h09);
    for (int k = 0; k < 6; k++) tick();
    chk("R3 PWM period top+1", count, 0);
    for (int j = 1; j <= 12; j++) begin
      tick();
      if (count !== 8'(j % 6)) chk("R3 PWM count sequence", count, j % 6);
      if (outTrue[0] !== (count == 1)) chk("R9 true pin phase", outTrue[0], count == 1);
      if (outComp[0] !== (count >= 3 && count <= 5)) chk("R9 comp pin phase", outComp[0], count >= 3);
      if (outTrue[0] && outComp[0]) chk("R8 pair overlap", 1, 0);
      hiCnt += outTrue[0];
      loCnt += outComp[0];
    end
    chk("R9 true high ticks over two periods", hiCnt, 2);
    chk("R9 comp high ticks over two periods", loCnt, 6);
  endtask

  task automatic constLevel(input string req, input logic [7:0] ctrl, input logic [7:0] cmp,
                            input logic expT, input logic expC);
    int bad = 0;
    wr(3'd0, ctrl);
    wr(3'd3, cmp);
    tick(); tick();
    for (int k = 0; k < 6; k++) begin
      tick();
      if (outTrue[0] !== expT || outComp[0] !== expC) bad++;
    end
    chk(req, bad, 0);
    chk(req, {outTrue[0], outComp[0]}, {expT, expC});
  endtask

  task automatic testPwmConst();
    constLevel("R10 compare zero", 8'h09, 8'd0, 1'b0, 1'b1);
    constLevel("R10 compare at top", 8'h09, 8'd5, 1'b1, 1'b0);
    constLevel("R10 inverted compare at top", 8'h19, 8'd5, 1'b0, 1'b1);
    constLevel("R11 PWM mode off pair", 8'h01, 8'd2, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCountHold();
    testMatchActions();
    testSoftWrite();
    testFlagClear();
    testNaturalWrap();
    testForce();
    testPwmWave();
    testPwmConst();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule